// File: doc/BRIEF.md
# Subtractive Greatest Common Divisor Unit

This unit finds the greatest common divisor of two nonzero unsigned operands. It uses only subtraction. A small controller steers a datapath with two working registers (`a_q` and `b_q`), two-input selectors in front of each register, a not-equal flag, a less-than flag, two subtractors and an output register. The controller drives only the selector and load lines. It branches only on the two comparator flags.

The unit waits idle until `start` is seen high. It then copies both operand inputs into the working registers in a single cycle. On each pass it compares the two values and replaces the larger one with the difference. When the two values match, that common value is the answer. The unit copies it into the output register, pulses `done` for one cycle and goes back to idle. The result stays on `result` until the next computation completes.

Operands of zero are outside the operating range. The caller must not supply them.

Top module: `gcd_fsmd`

## Requirements
- R1: A synchronous active-high `rst` clears `result` to 0 and `done` to 0, and leaves the unit idle.
- R2: While idle with `start` low, the unit stays idle. `done` remains 0 and `result` does not change. A computation begins at the first clock edge where `start` is high.
- R3: Both operand inputs are captured together, at the clock edge one cycle after the edge where `start` was sampled. Changes to `a_in`/`b_in` after that edge do not affect the computation.
- R4: Each pass subtracts the smaller working value from the larger. Each subtraction takes two cycles. With n subtractions, `done` is high after the (2n+3)-th clock edge after the edge where `start` was sampled.
- R5: For nonzero operands, `result` equals the greatest common divisor of `a_in` and `b_in`. For example, 42 and 8 give 2.
- R6: `done` is high for exactly one cycle per computation. It is high in the same cycle in which `result` first shows the new value.
- R7: Between completions, `result` holds its value regardless of `a_in`, `b_in` or the cycle count.
- R8: `start` is sampled only when idle. While a computation runs, `start` and the operand inputs have no effect on its result or its latency.
- R9: Equal operands need no subtraction. `result` equals that operand, and `done` comes after the 3rd edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a computation; sampled only when idle |
| a_in | input | W | First operand, nonzero |
| b_in | input | W | Second operand, nonzero |
| result | output | W | Last computed divisor, held until the next completion |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
Directed pairs are chosen to make different control paths run:
- 42 and 8 exercise both subtraction directions and mix them.
- Equal operands skip the loop entirely.
- 1 against the maximum value gives the longest run of a single subtraction direction, in both operand orders.
- Coprime pairs make sure the loop ends at 1.

Random nonzero pairs then cover many mixes of the two directions. Each pair is checked for both the value and the exact cycle count, which is 2n+3. The count tells apart a unit that gets the right answer with the wrong state sequence.

Separate runs hold `start` high and change the operands while the unit is busy, and change the operands while idle. Those runs check that neither disturbs the result.

// File: rtl/gcd_fsmd.sv
module gcd_fsmd #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] result,
  output logic         done
);

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_CMP, S_SUBA, S_SUBB, S_OUT
  } state_t;

  state_t st, st_nx;

  logic [W-1:0] a_q, b_q, d_q;
  logic         done_q;

  logic sel_a, sel_b, ld_a, ld_b, ld_d;
  logic ne_f, lt_f;

  assign ne_f = (a_q != b_q);
  assign lt_f = (a_q < b_q);

  always_comb begin
    st_nx = st;
    sel_a = 1'b0;
    sel_b = 1'b0;
    ld_a  = 1'b0;
    ld_b  = 1'b0;
    ld_d  = 1'b0;
    case (st)
      S_IDLE: if (start) st_nx = S_LOAD;
      S_LOAD: begin
        ld_a  = 1'b1;
        ld_b  = 1'b1;
        st_nx = S_CMP;
      end
      S_CMP: begin
        if (!ne_f)     st_nx = S_OUT;
        else if (lt_f) st_nx = S_SUBB;
        else           st_nx = S_SUBA;
      end
      S_SUBA: begin
        sel_a = 1'b1;
        ld_a  = 1'b1;
        st_nx = S_CMP;
      end
      S_SUBB: begin
        sel_b = 1'b1;
        ld_b  = 1'b1;
        st_nx = S_CMP;
      end
      S_OUT: begin
        ld_d  = 1'b1;
        st_nx = S_IDLE;
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      a_q    <= '0;
      b_q    <= '0;
      d_q    <= '0;
      done_q <= 1'b0;
    end else begin
      st     <= st_nx;
      if (ld_a) a_q <= sel_a ? (a_q - b_q) : a_in;
      if (ld_b) b_q <= sel_b ? (b_q - a_q) : b_in;
      if (ld_d) d_q <= a_q;
      done_q <= ld_d;
    end
  end

  assign result = d_q;
  assign done   = done_q;

  p_idle_wait_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !start) |=> (st == S_IDLE));

  p_load_both_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOAD) |=> (a_q == $past(a_in) && b_q == $past(b_in)));

  p_sub_larger_r4: assert property (@(posedge clk) disable iff (rst)
    ((st == S_SUBA) |-> (a_q > b_q)) and ((st == S_SUBB) |-> (b_q > a_q)));

  p_equal_out_r5: assert property (@(posedge clk) disable iff (rst)
    (st == S_OUT) |=> (result == $past(a_q) && result == $past(b_q)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE) |=> (st != S_LOAD));

endmodule

// File: tb/gcd_fsmd_bench.sv
module gcd_fsmd_bench;
  localparam int W = 8;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [W-1:0] result;
  logic         done;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  gcd_fsmd #(.W(W)) u_gcd_fsmd (
    .clk(clk), .rst(rst), .start(start),
    .a_in(a_in), .b_in(b_in), .result(result), .done(done)
  );

  function automatic void ref_gcd(input int a, input int b, output int g, output int n);
    n = 0;
    while (a != b) begin
      if (a < b) b = b - a; else a = a - b;
      n++;
    end
    g = a;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input int hold,
                     output int res, output int lat, output int pulses);
    @(negedge clk);
    a_in = a; b_in = b; start = 1'b1;
    @(posedge clk);
    lat = 0;
    pulses = 0;
    @(negedge clk);
    if (hold == 0) start = 1'b0;
    while (1) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (hold > 0 && lat == 1) begin a_in = ~a; b_in = a ^ b; end
      if (lat >= hold) start = 1'b0;
      if (done) begin pulses++; break; end
      if (lat > 4000) break;
    end
    res = result;
    @(negedge clk);
    if (done) pulses++;
  endtask

  task automatic full(input string tag, input int a, input int b, input int hold);
    int g, n, res, lat, pulses;
    ref_gcd(a, b, g, n);
    run(a[W-1:0], b[W-1:0], hold, res, lat, pulses);
    chk({tag, " R5 value"}, res, g);
    chk({tag, " R4 latency"}, lat, 2*n + 3);
    chk({tag, " R6 single pulse"}, pulses, 1);
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int res, lat, pulses, held, seen;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 result after reset", int'(result), 0);
    chk("R1 done after reset", int'(done), 0);

    a_in = 8'd12; b_in = 8'd18; seen = 0;
    repeat (8) begin @(negedge clk); if (done) seen++; end
    chk("R2 idle no done", seen, 0);
    chk("R2 idle result", int'(result), 0);

    full("R5 42/8", 42, 8, 0);
    full("R9 equal", 77, 77, 0);
    full("R4 1/255", 1, 255, 0);
    full("R4 255/1", 255, 1, 0);
    full("R5 coprime", 97, 89, 0);
    full("R3 200/150", 200, 150, 0);

    full("R8 busy start", 42, 8, 10);
    seen = 0;
    repeat (6) begin @(negedge clk); if (done) seen++; end
    chk("R8 no relaunch", seen, 0);

    held = int'(result);
    a_in = 8'd5; b_in = 8'd3; seen = 0;
    repeat (12) begin @(negedge clk); if (done) seen++; end
    chk("R7 result held", int'(result), held);
    chk("R7 no done idle", seen, 0);

    for (int i = 0; i < 40; i++) begin
      int a, b;
      a = 1 + int'($urandom_range(254));
      b = 1 + int'($urandom_range(254));
      full("R5 random", a, b, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule